// File: doc/BRIEF.md
# Two-Way Intersection Signal Controller

This block sequences the lamps at a crossing of two roads, north-south and east-west. It has one red, one yellow and one green output per road. Right of way alternates between the roads in phases of fixed length. A countdown of the seconds left in the current phase is shown as two BCD digits for an external display driver. When a green ends, the road that is losing right of way first gets a short flashing-yellow gap. The road that is gaining right of way goes from red straight to green.

Time comes from a half-second enable pulse, `half_tick`, made by an external divider. Two half ticks make one second. The first half of each second is the lit half of the yellow flash.

Two modes override automatic control:
- **Night mode** darkens all red and green lamps and flashes both yellows.
- **Manual mode** freezes the countdown. Each rising edge of a step input then advances to the next phase, in the same order and with the same yellow gap as automatic control.

Leaving either mode restarts the current road's phase from the full count.

Top module: `sxc_top`

## Requirements
- R1: After reset, north-south shows green, east-west shows red, the count is 30 and the digits read tens=3, units=0.
- R2: Outside night mode, exactly one road shows red and the other shows green or yellow. Both greens are never lit together.
- R3: In automatic mode, the count decreases by one at every second boundary. A second boundary is every second `half_tick` pulse counted from reset.
- R4: While the count is 4 or less, the road that has right of way shows yellow instead of green. Its red stays off.
- R5: The yellow is lit in the first half of each second (after an even number of half ticks since reset) and dark in the second half.
- R6: At the second boundary where the count is 1, right of way passes to the other road and the count reloads to 30. The road that receives right of way goes from red directly to green.
- R7: In night mode, all four red and green lamps are off and both yellows flash as in R5. The count is held at 30 and the road with right of way does not change.
- R8: In manual mode, outside night mode, `half_tick` does not change the count or the road with right of way.
- R9: In manual mode, a rising edge of `step_in` does one of two things. If the count is above 4 (green), the count becomes 4, which is the yellow gap. If the count is 4 or less, right of way passes to the other road and the count becomes 30.
- R10: In the cycle after night mode and manual mode are both released, the count reloads to 30 and the road with right of way is kept.
- R11: Outside manual mode, `step_in` has no effect on the lamps or the count.
- R12: `cnt_tens` and `cnt_units` hold the count as BCD: the count divided by 10, and the count modulo 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle pulse every half second |
| night_en | input | 1 | Night mode select, level |
| manual_en | input | 1 | Manual mode select, level |
| step_in | input | 1 | Manual step; the rising edge is used |
| ns_red | output | 1 | North-south red lamp |
| ns_yel | output | 1 | North-south yellow lamp |
| ns_grn | output | 1 | North-south green lamp |
| ew_red | output | 1 | East-west red lamp |
| ew_yel | output | 1 | East-west yellow lamp |
| ew_grn | output | 1 | East-west green lamp |
| cnt_tens | output | 4 | Tens digit of the countdown, BCD |
| cnt_units | output | 4 | Units digit of the countdown, BCD |

## Verification
The embedded properties check the following on every cycle:
- the count stays in range;
- the count steps down by exactly one per second boundary in automatic mode;
- a direction swap and reload happen together at the end of a phase;
- the count is frozen in manual mode and holds at the full value in night mode;
- the half-second phase alternates on every half tick;
- no two greens are lit together, and red and green are dark at night.

Only the bench scenarios show the following:
- the exact lamp pattern at each point of a full two-road cycle;
- the flash being dark mid-second;
- the order of manual steps;
- that the road is kept when a mode is released;
- that a step in automatic mode changes nothing.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef enum logic {ROAD_NS = 1'b0, ROAD_EW = 1'b1} road_e;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamp_t;
endpackage

// File: rtl/sxc_timebase.sv
module sxc_timebase (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  output logic rst_s,
  output logic half_q,
  output logic sec_pulse
);
  logic [1:0] sync_q;
  logic       half_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  always_comb begin
    half_d = half_q;
    if (half_tick) half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  assign sec_pulse = half_tick & half_q;

  a_r5_half_toggle: assert property (@(posedge clk) disable iff (!rst_s)
    half_tick |=> (half_q != $past(half_q)));
  a_r5_half_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !half_tick |=> $stable(half_q));
endmodule

// File: rtl/sxc_phase_fsm.sv
module sxc_phase_fsm
  import sxc_pkg::*;
#(
  parameter int PHASE_SECS = 30,
  parameter int AMBER_SECS = 4,
  localparam int CW = $clog2(PHASE_SECS + 1)
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic          sec_pulse,
  input  logic          night_en,
  input  logic          manual_en,
  input  logic          step_in,
  output road_e         go_road,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL  = CW'(PHASE_SECS);
  localparam logic [CW-1:0] AMBER = CW'(AMBER_SECS);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic          step_q, mode_q;
  logic          step_rise, mode_on, mode_exit;
  road_e         road_d;
  logic [CW-1:0] cnt_d;

  assign mode_on   = night_en | manual_en;
  assign step_rise = step_in & ~step_q;
  assign mode_exit = mode_q & ~mode_on;

  always_comb begin
    road_d = go_road;
    cnt_d  = cnt;
    if (night_en) begin
      cnt_d = FULL;
    end else if (mode_exit) begin
      cnt_d = FULL;
    end else if (manual_en) begin
      if (step_rise) begin
        if (cnt > AMBER) begin
          cnt_d = AMBER;
        end else begin
          cnt_d  = FULL;
          road_d = (go_road == ROAD_NS) ? ROAD_EW : ROAD_NS;
        end
      end
    end else if (sec_pulse) begin
      if (cnt == ONE) begin
        cnt_d  = FULL;
        road_d = (go_road == ROAD_NS) ? ROAD_EW : ROAD_NS;
      end else begin
        cnt_d = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      go_road <= ROAD_NS;
      cnt     <= FULL;
      step_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      go_road <= road_d;
      cnt     <= cnt_d;
      step_q  <= step_in;
      mode_q  <= mode_on;
    end
  end

  a_r3_range: assert property (@(posedge clk) disable iff (!rst_s)
    (cnt >= ONE) && (cnt <= FULL));
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_s)
    (!mode_on && !mode_q && sec_pulse && cnt > ONE) |=> (cnt == $past(cnt) - ONE));
  a_r6_swap: assert property (@(posedge clk) disable iff (!rst_s)
    (!mode_on && !mode_q && sec_pulse && cnt == ONE) |=>
      (cnt == FULL) && (go_road != $past(go_road)));
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_s)
    (manual_en && !night_en && mode_q && !step_rise) |=> $stable(cnt) && $stable(go_road));
  a_r7_night_hold: assert property (@(posedge clk) disable iff (!rst_s)
    night_en |=> (cnt == FULL) && $stable(go_road));
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_s)
    mode_exit |=> (cnt == FULL) && $stable(go_road));
endmodule

// File: rtl/sxc_lamp_drive.sv
module sxc_lamp_drive
  import sxc_pkg::*;
#(
  parameter int PHASE_SECS = 30,
  parameter int AMBER_SECS = 4,
  localparam int CW = $clog2(PHASE_SECS + 1)
) (
  input  logic          clk,
  input  logic          rst_s,
  input  road_e         go_road,
  input  logic [CW-1:0] cnt,
  input  logic          half_q,
  input  logic          night_en,
  output lamp_t         ns_lamp,
  output lamp_t         ew_lamp,
  output logic [3:0]    cnt_tens,
  output logic [3:0]    cnt_units
);
  localparam logic [CW-1:0] AMBER = CW'(AMBER_SECS);
  localparam logic [CW-1:0] TEN   = CW'(10);

  logic          flash_on, in_gap;
  lamp_t         go_lamp, stop_lamp;
  logic [CW-1:0] tens_w, units_w;

  assign flash_on = ~half_q;
  assign in_gap   = (cnt <= AMBER);

  always_comb begin
    if (night_en) begin
      go_lamp   = '{red: 1'b0, yel: flash_on, grn: 1'b0};
      stop_lamp = '{red: 1'b0, yel: flash_on, grn: 1'b0};
    end else begin
      go_lamp   = '{red: 1'b0, yel: in_gap & flash_on, grn: ~in_gap};
      stop_lamp = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    end
    if (go_road == ROAD_NS) begin
      ns_lamp = go_lamp;
      ew_lamp = stop_lamp;
    end else begin
      ns_lamp = stop_lamp;
      ew_lamp = go_lamp;
    end
  end

  assign tens_w    = cnt / TEN;
  assign units_w   = cnt % TEN;
  assign cnt_tens  = 4'(tens_w);
  assign cnt_units = 4'(units_w);

  a_r2_no_dual_green: assert property (@(posedge clk) disable iff (!rst_s)
    !(ns_lamp.grn && ew_lamp.grn));
  a_r2_one_red: assert property (@(posedge clk) disable iff (!rst_s)
    !night_en |-> $onehot0({ns_lamp.red, ew_lamp.red}) && (ns_lamp.red || ew_lamp.red));
  a_r7_night_dark: assert property (@(posedge clk) disable iff (!rst_s)
    night_en |-> !(ns_lamp.red || ns_lamp.grn || ew_lamp.red || ew_lamp.grn));
  a_r4_gap_no_green: assert property (@(posedge clk) disable iff (!rst_s)
    (cnt <= AMBER) |-> !(ns_lamp.grn || ew_lamp.grn));
endmodule

// File: rtl/sxc_top.sv
module sxc_top
  import sxc_pkg::*;
#(
  parameter int PHASE_SECS = 30,
  parameter int AMBER_SECS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       night_en,
  input  logic       manual_en,
  input  logic       step_in,
  output logic       ns_red,
  output logic       ns_yel,
  output logic       ns_grn,
  output logic       ew_red,
  output logic       ew_yel,
  output logic       ew_grn,
  output logic [3:0] cnt_tens,
  output logic [3:0] cnt_units
);
  localparam int CW = $clog2(PHASE_SECS + 1);

  logic          rst_s, half_q, sec_pulse;
  road_e         go_road;
  logic [CW-1:0] cnt;
  lamp_t         ns_lamp, ew_lamp;

  sxc_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .rst_s(rst_s), .half_q(half_q), .sec_pulse(sec_pulse)
  );

  sxc_phase_fsm #(.PHASE_SECS(PHASE_SECS), .AMBER_SECS(AMBER_SECS)) u_fsm (
    .clk(clk), .rst_s(rst_s), .sec_pulse(sec_pulse), .night_en(night_en),
    .manual_en(manual_en), .step_in(step_in), .go_road(go_road), .cnt(cnt)
  );

  sxc_lamp_drive #(.PHASE_SECS(PHASE_SECS), .AMBER_SECS(AMBER_SECS)) u_lamp (
    .clk(clk), .rst_s(rst_s), .go_road(go_road), .cnt(cnt), .half_q(half_q),
    .night_en(night_en), .ns_lamp(ns_lamp), .ew_lamp(ew_lamp),
    .cnt_tens(cnt_tens), .cnt_units(cnt_units)
  );

  assign ns_red = ns_lamp.red;
  assign ns_yel = ns_lamp.yel;
  assign ns_grn = ns_lamp.grn;
  assign ew_red = ew_lamp.red;
  assign ew_yel = ew_lamp.yel;
  assign ew_grn = ew_lamp.grn;
endmodule

// File: tb/sxc_top_test.sv
`timescale 1ns/1ps
module sxc_top_test;
  logic clk = 1'b0;
  logic rst_n, half_tick, night_en, manual_en, step_in;
  logic ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn;
  logic [3:0] cnt_tens, cnt_units;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sxc_top uut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .night_en(night_en),
    .manual_en(manual_en), .step_in(step_in), .ns_red(ns_red), .ns_yel(ns_yel),
    .ns_grn(ns_grn), .ew_red(ew_red), .ew_yel(ew_yel), .ew_grn(ew_grn),
    .cnt_tens(cnt_tens), .cnt_units(cnt_units)
  );

  // lamp vector order: {ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn}
  localparam logic [5:0] L_NSG = 6'b001100;
  localparam logic [5:0] L_NSY = 6'b010100;
  localparam logic [5:0] L_EWG = 6'b100001;
  localparam logic [5:0] L_EWY = 6'b100010;
  localparam logic [5:0] L_NYT = 6'b010010;
  localparam logic [5:0] L_OFF = 6'b000000;

  // entry: {seconds to advance[5:0], expected count[4:0], expected lamps[5:0]}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {6'd0,  5'd30, L_NSG},
    {6'd25, 5'd5,  L_NSG},
    {6'd1,  5'd4,  L_NSY},
    {6'd3,  5'd1,  L_NSY},
    {6'd1,  5'd30, L_EWG},
    {6'd26, 5'd4,  L_EWY},
    {6'd4,  5'd30, L_NSG}
  };

  task automatic check(input string req, input int exp_cnt, input logic [5:0] exp_l);
    logic [5:0] act_l;
    int act_cnt;
    act_l   = {ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn};
    act_cnt = int'(cnt_tens) * 10 + int'(cnt_units);
    checks++;
    if (act_l !== exp_l || cnt_tens !== 4'(exp_cnt / 10) || cnt_units !== 4'(exp_cnt % 10)) begin
      errors++;
      $display("FAIL %s: lamps %b count %0d (digits %0d,%0d) expected lamps %b count %0d",
               req, act_l, act_cnt, cnt_tens, cnt_units, exp_l, exp_cnt);
    end
  endtask

  task automatic half_pulse();
    @(negedge clk) half_tick = 1'b1;
    @(negedge clk) half_tick = 1'b0;
  endtask

  task automatic advance(input int secs);
    for (int i = 0; i < secs; i++) begin
      half_pulse();
      half_pulse();
    end
  endtask

  task automatic step_pulse();
    @(negedge clk) step_in = 1'b1;
    @(negedge clk) step_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; half_tick = 1'b0; night_en = 1'b0; manual_en = 1'b0; step_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", 30, L_NSG);

    // R3 R4 R6 R12: full two-road cycle from the vector table
    for (int v = 0; v < NV; v++) begin
      advance(int'(VEC[v][16:11]));
      @(negedge clk);
      check("R3 R4 R6 R12 cycle vector", int'(VEC[v][10:6]), VEC[v][5:0]);
    end

    // R5: yellow lit first half, dark second half
    advance(27);
    @(negedge clk);
    check("R5 flash lit", 3, L_NSY);
    half_pulse();
    @(negedge clk);
    check("R5 flash dark mid-second", 3, 6'b000100);
    half_pulse();
    @(negedge clk);
    check("R5 flash relit next second", 2, L_NSY);
    advance(2);
    @(negedge clk);
    check("R6 red to green direct", 30, L_EWG);

    // R7 and R10: night mode, then release
    advance(10);
    @(negedge clk);
    check("R3 mid phase", 20, L_EWG);
    @(negedge clk) night_en = 1'b1;
    @(negedge clk);
    check("R7 night yellows lit, count held", 30, L_NYT);
    half_pulse();
    @(negedge clk);
    check("R7 night yellows dark", 30, L_OFF);
    half_pulse();
    @(negedge clk);
    check("R7 night ignores second boundary", 30, L_NYT);
    @(negedge clk) night_en = 1'b0;
    @(negedge clk);
    check("R10 night release keeps road", 30, L_EWG);

    // R8 R9 R10: manual mode
    advance(10);
    @(negedge clk) manual_en = 1'b1;
    @(negedge clk);
    advance(2);
    @(negedge clk);
    check("R8 manual freeze", 20, L_EWG);
    step_pulse();
    check("R9 step green to gap", 4, L_EWY);
    step_pulse();
    check("R9 step gap to other green", 30, L_NSG);
    step_pulse();
    check("R9 step to gap again", 4, L_NSY);
    @(negedge clk) manual_en = 1'b0;
    @(negedge clk);
    check("R10 manual release restarts phase", 30, L_NSG);

    // R11: step ignored in automatic mode
    step_pulse();
    check("R11 step ignored in auto", 30, L_NSG);
    advance(1);
    @(negedge clk);
    check("R11 auto continues after step", 29, L_NSG);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual not done, expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule